// File: doc/BRIEF.md
# Octal Serial Bootstrap Loader

After a hard reset this block listens to the byte stream from a UART receiver and turns a plain-text octal program image into memory writes. The target is a processor with 12-bit memory words and 24-bit addresses. Octal digits gather in a shift accumulator. The next terminator character decides what the gathered value is used for. A comma stores it as a data word at the current pointer and steps the pointer. A closing bracket loads it into the pointer. A backslash makes it the execution start address and lets the processor run.

Until the start command arrives, the processor is kept in reset through the hold output. After the one-cycle start pulse, the loader ignores its input until the next reset. Carriage return and line feed can be used freely as leader or padding. Any other unexpected character sets a sticky error flag, and loading carries on.

Top module: `octboot_loader`

## Requirements
- R1: While reset is asserted and after it, `cpu_hold` is 1, and `mem_we`, `start_pulse` and `load_err` are 0. `start_addr`, `mem_addr`, `mem_wdata` and the internal pointer are 0.
- R2: Each byte from 0x30 to 0x37 ('0' to '7') shifts the 24-bit accumulator left by three bits and inserts the digit value. Only the low 24 bits are kept.
- R3: A comma (0x2C) produces `mem_we` = 1 for exactly the next cycle. In that cycle `mem_addr` is the pointer and `mem_wdata` is the low 12 bits of the accumulator.
- R4: After each comma write the pointer increases by one, wrapping modulo 2^24, so successive words go to successive addresses.
- R5: A closing bracket (0x5D) loads the accumulator into the pointer and causes no memory write.
- R6: A backslash (0x5C) copies the accumulator into `start_addr`, raises `start_pulse` for one cycle, and drops `cpu_hold` in that same cycle. `cpu_hold` then stays 0.
- R7: Once started, the loader ignores all input until reset: no writes, no further start pulse, no change to `start_addr` or `load_err`.
- R8: Carriage return (0x0D) and line feed (0x0A) have no effect, and they leave the accumulator unchanged.
- R9: Every terminator clears the accumulator afterwards. A terminator with no digits before it uses the value 0.
- R10: Any other byte sets `load_err`, which stays set until reset, and clears the accumulator. Loading continues normally after it.
- R11: A byte presented while `rx_valid` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset, released synchronously inside |
| rx_valid | input | 1 | Byte on `rx_byte` is valid this cycle |
| rx_byte | input | 8 | Received ASCII byte |
| mem_addr | output | 24 | Memory write address |
| mem_wdata | output | 12 | Memory write data |
| mem_we | output | 1 | One-cycle write strobe |
| cpu_hold | output | 1 | Holds the processor in reset while 1 |
| start_pulse | output | 1 | One-cycle start command |
| start_addr | output | 24 | Program start address |
| load_err | output | 1 | Sticky bad-character flag |

## Verification
The assertions check on every cycle the properties that hold at all times. A write strobe appears only after a comma, and the pointer is always one past the address just written. The hold output never rises again once it has fallen, the start pulse never lasts two cycles, and the error flag never clears outside reset. The accumulator's shift and clear rules are checked in the same way. The numeric results can only be shown by the bench's byte scenarios. These cover the octal values of deposited words, truncation of over-long fields, pointer loads and wrap-around, whitespace transparency, recovery after a bad character, and the silence that follows a start.

// File: rtl/octboot_pkg.sv
package octboot_pkg;
  typedef enum logic [2:0] {
    CK_NONE,
    CK_DIGIT,
    CK_DEPOSIT,
    CK_POINTER,
    CK_LAUNCH,
    CK_BLANK,
    CK_BAD
  } char_kind_e;

  localparam logic [7:0] CH_DEPOSIT = 8'h2C;
  localparam logic [7:0] CH_POINTER = 8'h5D;
  localparam logic [7:0] CH_LAUNCH  = 8'h5C;
  localparam logic [7:0] CH_CR      = 8'h0D;
  localparam logic [7:0] CH_LF      = 8'h0A;
  localparam logic [4:0] DIGIT_HI   = 5'b00110;  // 0x30..0x37
endpackage

// File: rtl/octboot_rst_sync.sv
module octboot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/octboot_classify.sv
module octboot_classify
  import octboot_pkg::*;
#(
  parameter int DIGIT_W = 3
) (
  input  logic               valid,
  input  logic [7:0]         byte_in,
  output char_kind_e         kind,
  output logic [DIGIT_W-1:0] digit
);
  always_comb begin
    digit = byte_in[DIGIT_W-1:0];
    if (!valid)                          kind = CK_NONE;
    else if (byte_in[7:3] == DIGIT_HI)   kind = CK_DIGIT;
    else if (byte_in == CH_DEPOSIT)      kind = CK_DEPOSIT;
    else if (byte_in == CH_POINTER)      kind = CK_POINTER;
    else if (byte_in == CH_LAUNCH)       kind = CK_LAUNCH;
    else if (byte_in == CH_CR || byte_in == CH_LF) kind = CK_BLANK;
    else                                 kind = CK_BAD;
  end
endmodule

// File: rtl/octboot_accum.sv
module octboot_accum #(
  parameter int ACC_W   = 24,
  parameter int DIGIT_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               clear,
  input  logic [DIGIT_W-1:0] digit,
  output logic [ACC_W-1:0]   acc
);
  localparam int KEEP_W = ACC_W - DIGIT_W;

  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = acc_q;
    if (clear)         acc_d = '0;
    else if (shift_en) acc_d = {acc_q[KEEP_W-1:0], digit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R2: inserted digit lands in the low bits, older bits move up
  a_r2_digit_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clear) |=> (acc_q[DIGIT_W-1:0] == $past(digit)) &&
                             (acc_q[ACC_W-1:DIGIT_W] == $past(acc_q[KEEP_W-1:0])));
  // R9: a terminator or bad byte empties the accumulator
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_q == '0));
endmodule

// File: rtl/octboot_ctrl.sv
module octboot_ctrl
  import octboot_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  char_kind_e        kind,
  input  logic [ADDR_W-1:0] acc,
  output logic              acc_shift,
  output logic              acc_clear,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              cpu_hold,
  output logic              start_pulse,
  output logic [ADDR_W-1:0] start_addr,
  output logic              load_err
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] ptr_q, ptr_d, addr_q, addr_d, start_q, start_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic we_q, we_d, hold_q, hold_d, pulse_q, pulse_d, err_q, err_d;

  always_comb begin
    ptr_d   = ptr_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    start_d = start_q;
    hold_d  = hold_q;
    err_d   = err_q;
    we_d    = 1'b0;
    pulse_d = 1'b0;
    acc_shift = 1'b0;
    acc_clear = 1'b0;
    if (hold_q) begin
      case (kind)
        CK_DIGIT: acc_shift = 1'b1;
        CK_DEPOSIT: begin
          we_d      = 1'b1;
          addr_d    = ptr_q;
          wdata_d   = acc[DATA_W-1:0];
          ptr_d     = ptr_q + ONE;
          acc_clear = 1'b1;
        end
        CK_POINTER: begin
          ptr_d     = acc;
          acc_clear = 1'b1;
        end
        CK_LAUNCH: begin
          start_d   = acc;
          pulse_d   = 1'b1;
          hold_d    = 1'b0;
          acc_clear = 1'b1;
        end
        CK_BAD: begin
          err_d     = 1'b1;
          acc_clear = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      start_q <= '0;
      we_q    <= 1'b0;
      hold_q  <= 1'b1;
      pulse_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      start_q <= start_d;
      we_q    <= we_d;
      hold_q  <= hold_d;
      pulse_q <= pulse_d;
      err_q   <= err_d;
    end
  end

  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;
  assign mem_we      = we_q;
  assign cpu_hold    = hold_q;
  assign start_pulse = pulse_q;
  assign start_addr  = start_q;
  assign load_err    = err_q;

  // R3: a write strobe only follows an accepted comma
  a_r3_we_after_comma: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> $past(kind == CK_DEPOSIT && hold_q));
  // R4: pointer sits one past the address just written
  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (ptr_q == addr_q + ONE));
  // R6: hold falls together with the start pulse and never returns
  a_r6_hold_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> pulse_q);
  a_r6_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |=> !hold_q);
  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  // R7: nothing is written once the processor runs
  a_r7_quiet_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_q |=> (!we_q && !pulse_q && $stable(start_q) && $stable(err_q)));
  // R10: error flag is sticky
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/octboot_loader.sv
module octboot_loader
  import octboot_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              cpu_hold,
  output logic              start_pulse,
  output logic [ADDR_W-1:0] start_addr,
  output logic              load_err
);
  localparam int DIGIT_W = 3;

  logic               rst_n_int;
  char_kind_e         kind;
  logic [DIGIT_W-1:0] digit;
  logic [ADDR_W-1:0]  acc;
  logic               acc_shift, acc_clear;

  octboot_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_int)
  );

  octboot_classify #(.DIGIT_W(DIGIT_W)) u_class (
    .valid(rx_valid), .byte_in(rx_byte), .kind(kind), .digit(digit)
  );

  octboot_accum #(.ACC_W(ADDR_W), .DIGIT_W(DIGIT_W)) u_acc (
    .clk(clk), .rst_n(rst_n_int), .shift_en(acc_shift), .clear(acc_clear),
    .digit(digit), .acc(acc)
  );

  octboot_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n_int), .kind(kind), .acc(acc),
    .acc_shift(acc_shift), .acc_clear(acc_clear),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .cpu_hold(cpu_hold), .start_pulse(start_pulse), .start_addr(start_addr),
    .load_err(load_err)
  );
endmodule

// File: tb/test_octboot_loader.sv
module test_octboot_loader;
  localparam int PERIOD = 10;
  localparam int NVEC = 27;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic [23:0] mem_addr, start_addr;
  logic [11:0] mem_wdata;
  logic        mem_we, cpu_hold, start_pulse, load_err;
  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  octboot_loader i_octboot_loader (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .cpu_hold(cpu_hold), .start_pulse(start_pulse), .start_addr(start_addr),
    .load_err(load_err)
  );

  // {byte, expected we, expected addr, expected data}
  localparam logic [44:0] VEC [NVEC] = '{
    {8'h31, 1'b0, 24'd0,  12'd0},     // R5: pointer load 0o100
    {8'h30, 1'b0, 24'd0,  12'd0},
    {8'h30, 1'b0, 24'd0,  12'd0},
    {8'h5D, 1'b0, 24'd0,  12'd0},
    {8'h31, 1'b0, 24'd0,  12'd0},     // R2 R3: word 0o1234
    {8'h32, 1'b0, 24'd0,  12'd0},
    {8'h33, 1'b0, 24'd0,  12'd0},
    {8'h34, 1'b0, 24'd0,  12'd0},
    {8'h2C, 1'b1, 24'd64, 12'd668},
    {8'h37, 1'b0, 24'd64, 12'd668},   // R4: next address
    {8'h37, 1'b0, 24'd64, 12'd668},
    {8'h37, 1'b0, 24'd64, 12'd668},
    {8'h37, 1'b0, 24'd64, 12'd668},
    {8'h2C, 1'b1, 24'd65, 12'd4095},
    {8'h2C, 1'b1, 24'd66, 12'd0},     // R9: empty field
    {8'h0D, 1'b0, 24'd66, 12'd0},     // R8: whitespace
    {8'h0A, 1'b0, 24'd66, 12'd0},
    {8'h35, 1'b0, 24'd66, 12'd0},
    {8'h0A, 1'b0, 24'd66, 12'd0},
    {8'h36, 1'b0, 24'd66, 12'd0},
    {8'h2C, 1'b1, 24'd67, 12'd46},
    {8'h31, 1'b0, 24'd67, 12'd46},    // R2: five digits, low 12 bits kept
    {8'h32, 1'b0, 24'd67, 12'd46},
    {8'h33, 1'b0, 24'd67, 12'd46},
    {8'h34, 1'b0, 24'd67, 12'd46},
    {8'h35, 1'b0, 24'd67, 12'd46},
    {8'h2C, 1'b1, 24'd68, 12'd1253}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1: state while reset is held
    chk("R1 hold", 32'(cpu_hold), 1);
    chk("R1 we", 32'(mem_we), 0);
    chk("R1 pulse", 32'(start_pulse), 0);
    chk("R1 err", 32'(load_err), 0);
    chk("R1 start_addr", 32'(start_addr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 addr after release", 32'(mem_addr), 0);

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][44:37]);
      chk($sformatf("R3 we vec %0d", i), 32'(mem_we), 32'(VEC[i][36]));
      if (VEC[i][36]) begin
        chk($sformatf("R4 addr vec %0d", i), 32'(mem_addr), 32'(VEC[i][35:12]));
        chk($sformatf("R2 data vec %0d", i), 32'(mem_wdata), 32'(VEC[i][11:0]));
      end
      chk($sformatf("R10 err vec %0d", i), 32'(load_err), 0);
    end

    // R11: comma byte without valid
    @(negedge clk);
    rx_byte = 8'h2C;
    @(negedge clk);
    chk("R11 no write", 32'(mem_we), 0);

    // R10: bad byte sets flag, clears accumulator, loading goes on
    send(8'h33);
    send(8'h78);
    chk("R10 err set", 32'(load_err), 1);
    send(8'h2C);
    chk("R10 write continues", 32'(mem_we), 1);
    chk("R10 addr", 32'(mem_addr), 69);
    chk("R10 data cleared", 32'(mem_wdata), 0);
    chk("R10 err sticky", 32'(load_err), 1);

    // R2 R5: nine digits load pointer, low 24 bits kept
    for (int k = 0; k < 9; k++) send(8'h37);
    send(8'h5D);
    chk("R5 no write", 32'(mem_we), 0);
    send(8'h2C);
    chk("R2 addr trunc", 32'(mem_addr), 32'h00FF_FFFF);
    send(8'h2C);
    chk("R4 wrap", 32'(mem_addr), 0);

    // R6: start at 0o2000
    send(8'h32); send(8'h30); send(8'h30); send(8'h30);
    send(8'h5C);
    chk("R6 pulse", 32'(start_pulse), 1);
    chk("R6 hold low", 32'(cpu_hold), 0);
    chk("R6 start_addr", 32'(start_addr), 1024);
    @(negedge clk);
    chk("R6 pulse one cycle", 32'(start_pulse), 0);
    chk("R6 hold stays", 32'(cpu_hold), 0);

    // R7: input ignored after start
    send(8'h2C);
    chk("R7 no write", 32'(mem_we), 0);
    send(8'h35);
    send(8'h5C);
    chk("R7 no pulse", 32'(start_pulse), 0);
    chk("R7 start kept", 32'(start_addr), 1024);

    // R1 again, then R9 empty start and R7 error frozen
    do_reset();
    send(8'h5C);
    chk("R9 empty start", 32'(start_addr), 0);
    chk("R6 pulse 2", 32'(start_pulse), 1);
    send(8'h78);
    chk("R7 err frozen", 32'(load_err), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule